// File: doc/BRIEF.md
# Divider Value Programming Port

This block receives the settings for a clock synthesizer's two dividers: a 9-bit feedback divider value (M) and a 3-bit output divider code (N). The values arrive either on parallel buses or one bit at a time over a three-wire serial port (serial clock, serial data, load strobe). The block presents the active M and N values to the dividers and drives a test output that shows the bit about to leave the serial shift register.

A level input selects the parallel behaviour. While it is low, the buses flow straight to the divider outputs. When it rises, the bus values are captured and held. While it is high, the serial port is live: bits shift into a 12-bit register on rising serial clock edges, the divider outputs follow that register while the load strobe is high, and they freeze when the strobe falls. A serial load therefore replaces values captured from the buses. An asynchronous active-low master reset clears every register and forces every output low. All strobes are sampled with a free-running system clock, which must run at least four times faster than the serial clock.

Top module: `divcfg_port`

## Requirements
- R1: While `rst_ni` is low, `m_div_o`, `n_div_o` and `test_o` are all zero, whatever the other inputs are.
- R2: Reset clears the shift register and the held divider value: after release, with the latch input high, the outputs read zero both while the load strobe is high and after it falls.
- R3: While `par_latch_i` is low, `m_div_o` equals `m_bus_i`, `n_div_o` equals `n_bus_i` without any clock edge, and `test_o` is low.
- R4: On the rising edge of `par_latch_i` the bus values are captured. Later bus changes and serial shifting do not alter the outputs while the load strobe stays low.
- R5: When `par_latch_i` returns low, the outputs follow the buses again.
- R6: The serial word is 12 bits, sent MSB first. The first bit shifted in becomes `m_div_o[8]` and the last becomes `n_div_o[0]` (word = {M, N}).
- R7: Serial clock edges do not shift the register while the load strobe is high or while `par_latch_i` is low.
- R8: While `par_latch_i` and `ser_load_i` are both high, the outputs track the shift register. This overrides any value captured from the buses.
- R9: After `ser_load_i` falls, the outputs keep the transferred value while new bits are shifted in.
- R10: While `par_latch_i` is high, `test_o` shows the shift register MSB, which is the bit shifted in twelve serial clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous assert |
| m_bus_i | input | 9 | Parallel feedback divider value |
| n_bus_i | input | 3 | Parallel output divider code |
| par_latch_i | input | 1 | Low: buses pass through; rising: capture; high: serial port live |
| ser_clk_i | input | 1 | Serial shift clock, rising edge active |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | Serial load strobe; high tracks register, falling edge holds |
| m_div_o | output | 9 | Active feedback divider value |
| n_div_o | output | 3 | Active output divider code |
| test_o | output | 1 | Shift register MSB while serial port live, else low |

## Verification
The bench loads a serial word over a value captured from the buses and checks that the word wins. A design that let the parallel capture take priority would keep the stale bus value. It pulses the serial clock while the strobe is high and while the latch input is low. A register that shifted in those states would show a corrupted word once the outputs track it again. It checks bit order through an asymmetric word, which catches a reversed or off-by-one shift. It also checks that outputs stay frozen after the strobe falls while new bits arrive, and that reset clears a register that was already loaded.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int unsigned M_WIDTH_DEF = 9;
  localparam int unsigned N_WIDTH_DEF = 3;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // index of each strobe inside the synchronised vector
  typedef enum logic [1:0] {
    SIG_LATCH = 2'd0,
    SIG_LOAD  = 2'd1,
    SIG_SCLK  = 2'd2,
    SIG_SDAT  = 2'd3
  } strobe_idx_e;

  localparam int unsigned STROBE_COUNT = 4;

  // source of the held divider word
  typedef enum logic [1:0] {
    HOLD_FROM_BUS   = 2'd0,
    HOLD_FROM_SHIFT = 2'd1,
    HOLD_KEEP       = 2'd2
  } hold_src_e;
endpackage

// File: rtl/divcfg_rst_sync.sv
module divcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic             load_i,
  input  logic             sclk_i,
  input  logic             sdat_i,
  output logic [WIDTH-1:0] word_o
);
  logic             sclk_prev_q;
  logic             sclk_rise;
  logic             shift_en;
  logic [WIDTH-1:0] sreg_q;
  logic [WIDTH-1:0] sreg_d;

  always_comb begin
    sclk_rise = sclk_i & ~sclk_prev_q;
    shift_en  = latch_i & ~load_i & sclk_rise;
    sreg_d    = sreg_q;
    if (shift_en) sreg_d = {sreg_q[WIDTH-2:0], sdat_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      sreg_q      <= '0;
    end else begin
      sclk_prev_q <= sclk_i;
      sreg_q      <= sreg_d;
    end
  end

  assign word_o = sreg_q;

  // R6: a new bit enters at the LSB and older bits move toward the MSB
  a_r6_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> (sreg_q[0] == $past(sdat_i)) &&
                 (sreg_q[WIDTH-1:1] == $past(sreg_q[WIDTH-2:0])));

  // R7: no shift while strobe high or latch input low
  a_r7_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i || !latch_i) |=> $stable(sreg_q));
endmodule

// File: rtl/divcfg_hold.sv
module divcfg_hold #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] bus_word_i,
  input  logic [WIDTH-1:0] shift_word_i,
  output logic [WIDTH-1:0] hold_o
);
  import divcfg_pkg::*;

  hold_src_e        src;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  always_comb begin
    if (!latch_i)    src = HOLD_FROM_BUS;
    else if (load_i) src = HOLD_FROM_SHIFT;
    else             src = HOLD_KEEP;
  end

  always_comb begin
    unique case (src)
      HOLD_FROM_BUS:   hold_d = bus_word_i;
      HOLD_FROM_SHIFT: hold_d = shift_word_i;
      default:         hold_d = hold_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  // R4 / R9: latched and strobe low -> held word frozen
  a_r4_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !load_i) |=> $stable(hold_q));

  // R8: strobe high -> held word follows the shift register
  a_r8_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && load_i) |=> (hold_q == $past(shift_word_i)));
endmodule

// File: rtl/divcfg_port.sv
module divcfg_port #(
  parameter int unsigned M_WIDTH     = divcfg_pkg::M_WIDTH_DEF,
  parameter int unsigned N_WIDTH     = divcfg_pkg::N_WIDTH_DEF,
  parameter int unsigned SYNC_STAGES = divcfg_pkg::SYNC_STAGES_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [M_WIDTH-1:0] m_bus_i,
  input  logic [N_WIDTH-1:0] n_bus_i,
  input  logic               par_latch_i,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  input  logic               ser_load_i,
  output logic [M_WIDTH-1:0] m_div_o,
  output logic [N_WIDTH-1:0] n_div_o,
  output logic               test_o
);
  import divcfg_pkg::*;

  localparam int unsigned WORD_W = M_WIDTH + N_WIDTH;

  logic                    rst_sync_n;
  logic [STROBE_COUNT-1:0] strobe_raw;
  logic [STROBE_COUNT-1:0] strobe_s;
  logic [WORD_W-1:0]       bus_word;
  logic [WORD_W-1:0]       shift_word;
  logic [WORD_W-1:0]       hold_word;
  logic [WORD_W-1:0]       out_word;

  always_comb begin
    strobe_raw            = '0;
    strobe_raw[SIG_LATCH] = par_latch_i;
    strobe_raw[SIG_LOAD]  = ser_load_i;
    strobe_raw[SIG_SCLK]  = ser_clk_i;
    strobe_raw[SIG_SDAT]  = ser_dat_i;
  end

  assign bus_word = {m_bus_i, n_bus_i};

  divcfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  divcfg_sync #(.WIDTH(STROBE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .async_i (strobe_raw),
    .sync_o  (strobe_s)
  );

  divcfg_shift #(.WIDTH(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .latch_i (strobe_s[SIG_LATCH]),
    .load_i  (strobe_s[SIG_LOAD]),
    .sclk_i  (strobe_s[SIG_SCLK]),
    .sdat_i  (strobe_s[SIG_SDAT]),
    .word_o  (shift_word)
  );

  divcfg_hold #(.WIDTH(WORD_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .latch_i      (strobe_s[SIG_LATCH]),
    .load_i       (strobe_s[SIG_LOAD]),
    .bus_word_i   (bus_word),
    .shift_word_i (shift_word),
    .hold_o       (hold_word)
  );

  always_comb begin
    if (!rst_sync_n)              out_word = '0;
    else if (!strobe_s[SIG_LATCH]) out_word = bus_word;
    else                          out_word = hold_word;
  end

  assign m_div_o = out_word[WORD_W-1:N_WIDTH];
  assign n_div_o = out_word[N_WIDTH-1:0];
  assign test_o  = rst_sync_n & strobe_s[SIG_LATCH] & shift_word[WORD_W-1];

  // R1: reset forces every output low
  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (m_div_o == '0) && (n_div_o == '0) && !test_o);

  // R3: pass-through mode keeps test output low and follows the buses
  a_r3_pass: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !strobe_s[SIG_LATCH] |-> !test_o && (m_div_o == m_bus_i) && (n_div_o == n_bus_i));
endmodule

// File: tb/divcfg_port_tb.sv
module divcfg_port_tb_top;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [8:0] m_bus_i;
  logic [2:0] n_bus_i;
  logic       par_latch_i;
  logic       ser_clk_i;
  logic       ser_dat_i;
  logic       ser_load_i;
  logic [8:0] m_div_o;
  logic [2:0] n_div_o;
  logic       test_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  divcfg_port dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .m_bus_i     (m_bus_i),
    .n_bus_i     (n_bus_i),
    .par_latch_i (par_latch_i),
    .ser_clk_i   (ser_clk_i),
    .ser_dat_i   (ser_dat_i),
    .ser_load_i  (ser_load_i),
    .m_div_o     (m_div_o),
    .n_div_o     (n_div_o),
    .test_o      (test_o)
  );

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [11:0] w);
    check(req, {m_div_o, n_div_o}, w);
  endtask

  task automatic ser_bit(input logic b);
    ser_dat_i = b;
    wait_clks(3);
    ser_clk_i = 1'b1;
    wait_clks(4);
    ser_clk_i = 1'b0;
    wait_clks(3);
  endtask

  task automatic ser_word(input logic [11:0] w);
    for (int i = 11; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    m_bus_i = 9'h1FF; n_bus_i = 3'h7;
    par_latch_i = 1'b0; ser_load_i = 1'b0; ser_clk_i = 1'b0; ser_dat_i = 1'b1;
    wait_clks(4);
    check("R1 pass mode in reset", {m_div_o, n_div_o}, 12'h000);
    check("R1 test_o in reset", {11'b0, test_o}, 12'h000);
    par_latch_i = 1'b1; ser_load_i = 1'b1;
    wait_clks(4);
    check("R1 latched mode in reset", {m_div_o, n_div_o}, 12'h000);
    rst_ni = 1'b1;
    wait_clks(8);
    check_word("R2 track cleared register", 12'h000);
    ser_load_i = 1'b0;
    wait_clks(6);
    check_word("R2 held value cleared", 12'h000);
    check("R2 test_o cleared", {11'b0, test_o}, 12'h000);
  endtask

  task automatic t_pass;
    par_latch_i = 1'b0;
    m_bus_i = 9'h1A5; n_bus_i = 3'h6;
    wait_clks(6);
    check_word("R3 pass-through", {9'h1A5, 3'h6});
    check("R3 test_o low", {11'b0, test_o}, 12'h000);
    #1 m_bus_i = 9'h033; n_bus_i = 3'h1;
    #1 check_word("R3 pass-through no clock", {9'h033, 3'h1});
  endtask

  task automatic t_par_latch;
    m_bus_i = 9'h0F0; n_bus_i = 3'h5;
    wait_clks(2);
    par_latch_i = 1'b1;
    wait_clks(6);
    m_bus_i = 9'h10F; n_bus_i = 3'h2;
    wait_clks(6);
    check_word("R4 captured bus held", {9'h0F0, 3'h5});
    par_latch_i = 1'b0;
    wait_clks(6);
    check_word("R5 pass-through resumes", {9'h10F, 3'h2});
  endtask

  task automatic t_serial_override;
    logic [11:0] w1 = 12'hA5C;
    logic [11:0] w2 = 12'h3C3;
    m_bus_i = 9'h155; n_bus_i = 3'h3;
    wait_clks(2);
    par_latch_i = 1'b1;
    wait_clks(6);
    ser_word(w1);
    check_word("R4 shifting leaves latched bus value", {9'h155, 3'h3});
    check("R10 test_o shows first bit", {11'b0, test_o}, {11'b0, w1[11]});
    ser_load_i = 1'b1;
    wait_clks(6);
    check_word("R8 serial overrides parallel", w1);
    check("R6 first bit lands in M MSB", {11'b0, m_div_o[8]}, {11'b0, w1[11]});
    check("R6 last bit lands in N LSB", {11'b0, n_div_o[0]}, {11'b0, w1[0]});
    ser_load_i = 1'b0;
    wait_clks(6);
    ser_word(w2);
    check_word("R9 held after strobe falls", w1);
    check("R10 test_o after second word", {11'b0, test_o}, {11'b0, w2[11]});
    ser_load_i = 1'b1;
    wait_clks(6);
    check_word("R8 tracks new register", w2);
  endtask

  task automatic t_ignored_clocks;
    logic [11:0] w2 = 12'h3C3;
    for (int i = 0; i < 3; i++) ser_bit(1'b1);
    check_word("R7 no shift while strobe high", w2);
    ser_load_i = 1'b0;
    wait_clks(4);
    par_latch_i = 1'b0;
    wait_clks(6);
    for (int i = 0; i < 3; i++) ser_bit(1'b1);
    par_latch_i = 1'b1;
    wait_clks(6);
    ser_load_i = 1'b1;
    wait_clks(6);
    check_word("R7 no shift while latch low", w2);
  endtask

  task automatic t_reset_clears;
    rst_ni = 1'b0;
    wait_clks(3);
    check_word("R1 outputs low on reset", 12'h000);
    rst_ni = 1'b1;
    wait_clks(8);
    check_word("R2 loaded register cleared", 12'h000);
    check("R2 test_o after reset", {11'b0, test_o}, 12'h000);
    ser_load_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass();
    t_par_latch();
    t_serial_override();
    t_ignored_clocks();
    t_reset_clears();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule